// File: doc/BRIEF.md
# Overcurrent Fault Retry Controller

This block supervises the protection logic for a pair of H-bridges that share one open-drain fault pin. Each bridge has its own raw overcurrent flag. A flag has to stay high for longer than a programmable deglitch window before it counts as a fault. A confirmed fault switches off only that bridge and pulls the shared fault pin low. The bridge then waits a fixed hold-off time and switches back on. If the overcurrent is still there, the filter starts again from zero and the cycle repeats. If it is gone, the bridge keeps running.

Three chip-wide conditions feed the same two outputs: an over-temperature flag, an undervoltage flag and a supply-ready flag. Over-temperature turns off every bridge and pulls the fault pin low only while it lasts. It does not touch the per-bridge state. Undervoltage and a supply that is not yet ready do the same, and they also clear all deglitch and hold-off state. All inputs arrive already synchronised to `clk`. The deglitch and hold-off durations are clock-count parameters, so one hold-off of roughly a millisecond is simply a large count. The block has no streaming data path: every pin is a plain level.

Top module: `ocf_retry_ctrl`

## Requirements
- R1: An overcurrent flag high on DEGLITCH_CYC or fewer consecutive clock samples has no effect. On DEGLITCH_CYC+1 consecutive high samples, that bridge's enable drops in the cycle after the last sample.
- R2: Bit i of `bridge_en_o` and bit i of `oc_raw_i` belong to bridge i. A fault on one bridge leaves the other bridge's enable high.
- R3: `fault_n_o` is 0 in every cycle in which any bridge is in its hold-off, including when a second bridge is still holding off after the first has recovered.
- R4: A hold-off lasts exactly RETRY_CYC cycles. When no other cause is present, the bridge enable returns to 1 and `fault_n_o` returns to 1 in the same cycle.
- R5: If the overcurrent flag is still high when a bridge is re-enabled, the deglitch count starts from zero. The bridge trips again after DEGLITCH_CYC+1 further high samples.
- R6: While `ovtemp_i` is 1, all enables are 0 and `fault_n_o` is 0 in that same cycle. When it clears, the outputs recover in the same cycle without any retry wait.
- R7: While `uvlo_i` is 1, all enables and `fault_n_o` are 0, and every hold-off and deglitch count is cleared. In the first cycle after it clears, all enables and `fault_n_o` are 1.
- R8: While `sup_ready_i` is 0, all enables and `fault_n_o` are 0, and internal state is cleared in the same way as for R7.
- R9: An overcurrent flag seen during a hold-off neither restarts nor lengthens that hold-off.
- R10: After `rst_n` is released, with `sup_ready_i`=1 and no fault flags, both enables are 1 and `fault_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw_i | input | NUM_BRIDGES | Raw overcurrent flag per bridge, synchronous |
| ovtemp_i | input | 1 | Die over-temperature flag |
| uvlo_i | input | 1 | Supply undervoltage flag |
| sup_ready_i | input | 1 | Internal supplies ready (1 = stable) |
| bridge_en_o | output | NUM_BRIDGES | Per-bridge permission to drive the FETs |
| fault_n_o | output | 1 | Level for the open-drain fault pin, 0 = pull low |

## Verification
A deglitch counter that is one count off shows up as a trip one cycle early or late, so the enable is checked on the exact cycle the count says. A hold-off counter that is wrong, or that reloads on a fresh overcurrent, changes when the enable and fault pin come back; this shows up within RETRY_CYC cycles. State that survives undervoltage or a not-ready supply shows up as an enable that stays low in the first cycle after the condition clears. A mix-up between bridges shows up as the wrong bit of `bridge_en_o` dropping.

// File: rtl/ocf_pkg.sv
package ocf_pkg;

  typedef enum logic {
    CH_RUN     = 1'b0,
    CH_HOLDOFF = 1'b1
  } ch_state_e;

  function automatic int cnt_width(input int max_val);
    if (max_val < 2) return 1;
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ocf_deglitch.sv
module ocf_deglitch #(
  parameter int DEGLITCH_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic oc,
  output logic trip
);
  localparam int DGW = ocf_pkg::cnt_width(DEGLITCH_CYC);
  localparam logic [DGW-1:0] DG_MAX = DGW'(DEGLITCH_CYC);

  logic [DGW-1:0] cnt_q;
  logic           at_max;

  assign at_max = (cnt_q == DG_MAX);
  assign trip   = arm && oc && at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || !arm || !oc) begin
      cnt_q <= '0;
    end else if (!at_max) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DG_MAX) else $error("deglitch count overran"); // R1

  AST_DG_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !oc |=> cnt_q == '0) else $error("count survived a low sample"); // R1

endmodule

// File: rtl/ocf_retry_timer.sv
module ocf_retry_timer
  import ocf_pkg::*;
#(
  parameter int RETRY_CYC = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trip,
  output logic holdoff
);
  localparam int RC  = (RETRY_CYC < 1) ? 1 : RETRY_CYC;
  localparam int RTW = cnt_width(RC - 1);
  localparam logic [RTW-1:0] RT_LAST = RTW'(RC - 1);

  ch_state_e      state_q;
  logic [RTW-1:0] cnt_q;

  assign holdoff = (state_q == CH_HOLDOFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_RUN;
      cnt_q   <= '0;
    end else if (clr) begin
      state_q <= CH_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CH_RUN: begin
          cnt_q <= '0;
          if (trip) state_q <= CH_HOLDOFF;
        end
        CH_HOLDOFF: begin
          if (cnt_q == RT_LAST) begin
            state_q <= CH_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= CH_RUN;
      endcase
    end
  end

  AST_HOLD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff && $past(holdoff) && !$past(clr)) |-> cnt_q != '0)
    else $error("hold-off count restarted"); // R9

  AST_TRIP_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(holdoff)) |-> $past(trip)) else $error("hold-off without trip"); // R1

endmodule

// File: rtl/ocf_fault_merge.sv
module ocf_fault_merge #(
  parameter int NUM_BRIDGES = 2
) (
  input  logic [NUM_BRIDGES-1:0] holdoff,
  input  logic                   ovtemp,
  input  logic                   uvlo,
  input  logic                   sup_ready,
  output logic [NUM_BRIDGES-1:0] bridge_en,
  output logic                   fault_n
);
  logic global_ok;

  assign global_ok = !ovtemp && !uvlo && sup_ready;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_en
    assign bridge_en[b] = global_ok && !holdoff[b];
  end

  assign fault_n = global_ok && !(|holdoff);

endmodule

// File: rtl/ocf_retry_ctrl.sv
module ocf_retry_ctrl #(
  parameter int NUM_BRIDGES  = 2,
  parameter int DEGLITCH_CYC = 300,
  parameter int RETRY_CYC    = 120000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BRIDGES-1:0] oc_raw_i,
  input  logic                   ovtemp_i,
  input  logic                   uvlo_i,
  input  logic                   sup_ready_i,
  output logic [NUM_BRIDGES-1:0] bridge_en_o,
  output logic                   fault_n_o
);
  logic                   clr_all;
  logic [NUM_BRIDGES-1:0] trip;
  logic [NUM_BRIDGES-1:0] holdoff;

  assign clr_all = uvlo_i || !sup_ready_i;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_ch
    ocf_deglitch #(
      .DEGLITCH_CYC(DEGLITCH_CYC)
    ) i_dg (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_all),
      .arm  (!holdoff[b]),
      .oc   (oc_raw_i[b]),
      .trip (trip[b])
    );

    ocf_retry_timer #(
      .RETRY_CYC(RETRY_CYC)
    ) i_rt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_all),
      .trip   (trip[b]),
      .holdoff(holdoff[b])
    );

    AST_TRIP_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (trip[b] && !clr_all) |=> !bridge_en_o[b]) else $error("bridge stayed on"); // R2
  end

  ocf_fault_merge #(
    .NUM_BRIDGES(NUM_BRIDGES)
  ) i_merge (
    .holdoff  (holdoff),
    .ovtemp   (ovtemp_i),
    .uvlo     (uvlo_i),
    .sup_ready(sup_ready_i),
    .bridge_en(bridge_en_o),
    .fault_n  (fault_n_o)
  );

  AST_FAULT_DURING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|holdoff) |-> !fault_n_o) else $error("fault pin released in hold-off"); // R3

  AST_OT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ovtemp_i |-> (bridge_en_o == '0 && !fault_n_o)) else $error("ovtemp leak"); // R6

  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |-> (bridge_en_o == '0 && !fault_n_o)) else $error("uvlo leak"); // R7

  AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> holdoff == '0) else $error("state survived uvlo"); // R7

  AST_NRDY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ready_i |=> holdoff == '0) else $error("state survived not-ready"); // R8

endmodule

// File: tb/test_ocf_retry_ctrl.sv
module test_ocf_retry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int D = 3;
  localparam int R = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] oc = 2'b00;
  logic       ot = 1'b0;
  logic       uv = 1'b0;
  logic       rdy = 1'b1;
  logic [1:0] en;
  logic       fn;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocf_retry_ctrl #(
    .NUM_BRIDGES (2),
    .DEGLITCH_CYC(D),
    .RETRY_CYC   (R)
  ) i_ocf_retry_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_raw_i   (oc),
    .ovtemp_i   (ot),
    .uvlo_i     (uv),
    .sup_ready_i(rdy),
    .bridge_en_o(en),
    .fault_n_o  (fn)
  );

  // {oc[1:0], ot, uv, rdy, exp_en[1:0], exp_fault_n}; written for D=3, R=5
  localparam int NV = 21;
  localparam logic [7:0] VEC [NV] = '{
    8'b00_0_0_1_11_1, // 0  R10 idle after reset
    8'b01_0_0_1_11_1, // 1  R1 pulse starts
    8'b01_0_0_1_11_1, // 2
    8'b01_0_0_1_11_1, // 3  three samples only
    8'b00_0_0_1_11_1, // 4  R1 short pulse ignored
    8'b01_0_0_1_11_1, // 5
    8'b01_0_0_1_11_1, // 6
    8'b01_0_0_1_11_1, // 7
    8'b01_0_0_1_11_1, // 8  fourth sample trips
    8'b01_0_0_1_10_1 & 8'b11111110, // 9  R2 only bridge 0 off, R3 fault low
    8'b00_0_0_1_10_0, // 10
    8'b00_0_0_1_10_0, // 11
    8'b00_0_0_1_10_0, // 12
    8'b00_0_0_1_10_0, // 13 last hold-off cycle
    8'b00_0_0_1_11_1, // 14 R4 re-enabled, fault released
    8'b00_1_0_1_00_0, // 15 R6 over-temperature
    8'b00_1_0_1_00_0, // 16
    8'b00_0_0_1_11_1, // 17 R6 immediate recovery
    8'b00_0_0_0_00_0, // 18 R8 supply not ready
    8'b00_0_1_1_00_0, // 19 R7 undervoltage
    8'b00_0_0_1_11_1  // 20
  };

  task automatic drive(input logic [1:0] o, input logic t, input logic u, input logic r);
    @(negedge clk);
    oc = o; ot = t; uv = u; rdy = r;
    #1;
  endtask

  task automatic chk(input logic [1:0] e_en, input logic e_fn, input string tag);
    tests++;
    if (en !== e_en || fn !== e_fn) begin
      fails++;
      $display("FAIL %s: bridge_en=%b exp %b, fault_n=%b exp %b", tag, en, e_en, fn, e_fn);
    end
  endtask

  task automatic fresh();
    drive(2'b00, 1'b0, 1'b1, 1'b1);
    drive(2'b00, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][7:6], VEC[k][5], VEC[k][4], VEC[k][3]);
      chk(VEC[k][2:1], VEC[k][0], $sformatf("table step %0d", k));
    end

    // R5 and R9: flag held high through hold-off and after re-enable
    fresh();
    for (int s = 0; s <= 2*D + R + 3; s++) begin
      logic e0;
      e0 = !((s >= D + 1 && s <= D + R) || s >= 2*D + R + 2);
      drive(2'b01, 1'b0, 1'b0, 1'b1);
      chk({1'b1, e0}, e0, $sformatf("R5 R9 retry loop s=%0d", s));
    end

    // R3 and R4: staggered trips on both bridges
    fresh();
    for (int s = 0; s <= D + R + 3; s++) begin
      logic o0, o1, e0, e1;
      o0 = (s <= D);
      o1 = (s >= 2 && s <= D + 2);
      e0 = !(s >= D + 1 && s <= D + R);
      e1 = !(s >= D + 3 && s <= D + R + 2);
      drive({o1, o0}, 1'b0, 1'b0, 1'b1);
      chk({e1, e0}, e0 && e1, $sformatf("R3 R4 stagger s=%0d", s));
    end

    // R7: undervoltage in the middle of a hold-off clears it
    fresh();
    for (int s = 0; s <= D; s++) begin
      drive(2'b10, 1'b0, 1'b0, 1'b1);
      chk(2'b11, 1'b1, "R1 bridge 1 deglitch");
    end
    drive(2'b00, 1'b0, 1'b0, 1'b1);
    chk(2'b01, 1'b0, "R2 bridge 1 held off");
    drive(2'b00, 1'b0, 1'b1, 1'b1);
    chk(2'b00, 1'b0, "R7 uvlo forces off");
    drive(2'b00, 1'b0, 1'b0, 1'b1);
    chk(2'b11, 1'b1, "R7 hold-off cleared");
    drive(2'b00, 1'b0, 1'b0, 1'b1);
    chk(2'b11, 1'b1, "R7 stays running");

    // R8: not-ready clears a partly filled deglitch count
    fresh();
    for (int s = 0; s < D; s++) drive(2'b01, 1'b0, 1'b0, 1'b1);
    drive(2'b01, 1'b0, 1'b0, 1'b0);
    chk(2'b00, 1'b0, "R8 not ready forces off");
    for (int s = 0; s <= D; s++) begin
      drive(2'b01, 1'b0, 1'b0, 1'b1);
      chk(2'b11, 1'b1, $sformatf("R8 count restarted s=%0d", s));
    end
    drive(2'b00, 1'b0, 1'b0, 1'b1);
    chk(2'b10, 1'b0, "R8 trip after full window");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule